// File: doc/BRIEF.md
# Two-Row Key Matrix Scanner with Recovery Hotkey

This block reads a small key matrix of two rows and three columns through a single row-select line and three active-low column inputs. A one-cycle start pulse launches a scan. The block first addresses the upper row and waits a programmable settle interval. It then captures the columns, switches to the lower row, waits again and captures the columns a second time. The six key states are packed into a fixed, non-linear bit vector.

From that single scan the block also makes two decisions. The first is a recovery request, raised when one particular three-key combination is held; extra keys do not block it. The second is a boot-delay code: zero when recovery is requested or when nothing is pressed, and two otherwise. All results appear together, alongside a one-cycle done pulse. The outputs hold their previous values until a scan completes, so downstream logic never sees a half-finished scan.

Column inputs are asynchronous to the clock and pass through a synchronizer. The settle wait is stretched by the synchronizer depth, so every sample reflects the column level after the full settle interval.

Top module: `kp2x3_scanner`

## Requirements
- R1: The row-select output is low while the upper row is addressed and high while the lower row is addressed. A scan addresses the upper row first, and the row select is low whenever no scan is running.
- R2: Let WAIT = SETTLE_CYCLES + SYNC_STAGES. The row select switches to the lower row exactly WAIT clock cycles after the edge that accepts the start pulse. The done pulse becomes visible exactly WAIT cycles after that switch.
- R3: Columns are active low: a column input at 0 while a row is addressed means the key at that row and column is pressed.
- R4: Upper-row keys land in the key vector as follows: column 0 in bit 5, column 1 in bit 3, column 2 in bit 4.
- R5: Lower-row keys land in the key vector as follows: column 0 in bit 2, column 1 in bit 1, column 2 in bit 0.
- R6: The recovery flag is 1 when key-vector bits 5, 3 and 0 are all set, whatever other keys are held, and 0 otherwise.
- R7: The 2-bit boot-delay code is 0 when recovery is requested or the key vector is all zero, and 2 in every other case.
- R8: The key vector, recovery flag and boot-delay code change only in the cycle in which done is high. They hold the previous scan's results while a scan is running, and done is high for exactly one cycle per scan.
- R9: A start pulse that arrives while a scan is running has no effect: the scan timing is unchanged and no second scan follows.
- R10: After reset the key vector, recovery flag, boot-delay code, done and row select are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that requests a scan |
| cols_n_i | input | 3 | Column levels, bit c is column c, active low |
| row_sel_o | output | 1 | Row select: 0 upper row, 1 lower row |
| keys_o | output | 6 | Pressed-key vector from the last completed scan |
| recovery_o | output | 1 | Recovery hotkey combination detected |
| boot_dly_o | output | 2 | Boot-delay code, 0 or 2 |
| done_o | output | 1 | One-cycle pulse when the outputs are refreshed |

## Verification
The bench builds the scanner with SETTLE_CYCLES = 4 and SYNC_STAGES = 2, so each row phase lasts six cycles and a whole scan takes twelve. This short interval puts the exact row-switch and done timing within reach of cycle counting. It also allows every single-key position, the hotkey with and without extra keys, the empty matrix and a start pulse injected mid-scan to be run back to back. With a short phase the bench can also look at the outputs at the row switch, to confirm they still hold the previous scan's results.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int ROW_COLS = 3;
  localparam int KEY_W    = 2 * ROW_COLS;
  localparam int DLY_W    = 2;
  localparam logic [DLY_W-1:0] DLY_NONE = 2'd0;
  localparam logic [DLY_W-1:0] DLY_HOLD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UPPER = 2'd1,
    ST_LOWER = 2'd2
  } scan_st_e;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int WIDTH   = 3,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= {WIDTH{RST_VAL}};
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/kp_seq.sv
module kp_seq
  import kp_pkg::*;
#(
  parameter int WAIT_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic row_sel_o,
  output logic accept_o,
  output logic cap_upper_o,
  output logic cap_lower_o
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WAIT_CYC - 1);

  scan_st_e        state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            row_sel_q, row_sel_d;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    row_sel_d   = row_sel_q;
    accept_o    = 1'b0;
    cap_upper_o = 1'b0;
    cap_lower_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o  = 1'b1;
          state_d   = ST_UPPER;
          cnt_d     = RELOAD;
          row_sel_d = 1'b0;
        end
      end
      ST_UPPER: begin
        if (cnt_q == '0) begin
          cap_upper_o = 1'b1;
          state_d     = ST_LOWER;
          cnt_d       = RELOAD;
          row_sel_d   = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_LOWER: begin
        if (cnt_q == '0) begin
          cap_lower_o = 1'b1;
          state_d     = ST_IDLE;
          row_sel_d   = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d   = ST_IDLE;
        row_sel_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      row_sel_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      row_sel_q <= row_sel_d;
    end
  end

  assign row_sel_o = row_sel_q;

  // R1
  upper_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> (!row_sel_q && state_q == ST_UPPER));

  // R1
  idle_row_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !row_sel_q);

  // R2
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && cnt_q != '0) |=> ($stable(row_sel_q) && state_q == $past(state_q)));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i && cnt_q != '0) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/kp_decode.sv
module kp_decode
  import kp_pkg::*;
(
  input  logic [ROW_COLS-1:0] upper_i,
  input  logic [ROW_COLS-1:0] lower_i,
  output logic [KEY_W-1:0]    keys_o,
  output logic                recovery_o,
  output logic [DLY_W-1:0]    delay_o
);
  always_comb begin
    keys_o    = '0;
    keys_o[5] = upper_i[0];
    keys_o[3] = upper_i[1];
    keys_o[4] = upper_i[2];
    keys_o[2] = lower_i[0];
    keys_o[1] = lower_i[1];
    keys_o[0] = lower_i[2];
    recovery_o = keys_o[5] & keys_o[3] & keys_o[0];
    if (recovery_o || keys_o == '0) delay_o = DLY_NONE;
    else                            delay_o = DLY_HOLD;
  end
endmodule

// File: rtl/kp2x3_scanner.sv
module kp2x3_scanner
  import kp_pkg::*;
#(
  parameter int SETTLE_CYCLES = 2000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [2:0]          cols_n_i,
  output logic                row_sel_o,
  output logic [5:0]          keys_o,
  output logic                recovery_o,
  output logic [1:0]          boot_dly_o,
  output logic                done_o
);
  localparam int WAIT_CYC = SETTLE_CYCLES + SYNC_STAGES;

  logic [ROW_COLS-1:0] cols_n_sync;
  logic [ROW_COLS-1:0] pressed;
  logic [ROW_COLS-1:0] upper_q;
  logic                accept, cap_upper, cap_lower;
  logic [KEY_W-1:0]    keys_d, keys_q;
  logic                rec_d, rec_q;
  logic [DLY_W-1:0]    dly_d, dly_q;
  logic                done_q;

  kp_sync #(.WIDTH(ROW_COLS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cols_n_i),
    .q_o   (cols_n_sync)
  );

  assign pressed = ~cols_n_sync;

  kp_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .row_sel_o   (row_sel_o),
    .accept_o    (accept),
    .cap_upper_o (cap_upper),
    .cap_lower_o (cap_lower)
  );

  kp_decode u_dec (
    .upper_i    (upper_q),
    .lower_i    (pressed),
    .keys_o     (keys_d),
    .recovery_o (rec_d),
    .delay_o    (dly_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
    end else if (accept) begin
      upper_q <= '0;
    end else if (cap_upper) begin
      upper_q <= pressed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keys_q <= '0;
      rec_q  <= 1'b0;
      dly_q  <= DLY_NONE;
    end else if (cap_lower) begin
      keys_q <= keys_d;
      rec_q  <= rec_d;
      dly_q  <= dly_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= cap_lower;
  end

  assign keys_o     = keys_q;
  assign recovery_o = rec_q;
  assign boot_dly_o = dly_q;
  assign done_o     = done_q;

  // R8
  keys_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(keys_o) |-> done_o);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  recovery_no_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_o |-> (boot_dly_o == 2'd0));

  // R6
  recovery_keys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_o |-> (keys_o[5] && keys_o[3] && keys_o[0]));
endmodule

// File: tb/kp2x3_scanner_tb.sv
module kp2x3_scanner_tb;
  localparam int SETTLE = 4;
  localparam int SYNC   = 2;
  localparam int W      = SETTLE + SYNC;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [2:0] cols_n_i;
  logic       row_sel_o;
  logic [5:0] keys_o;
  logic       recovery_o;
  logic [1:0] boot_dly_o;
  logic       done_o;

  logic [5:0] held;
  logic [8:0] exp_q [$];
  int checks = 0;
  int errors = 0;
  logic prev_done = 1'b0;
  logic [5:0] prev_keys = 6'd0;

  always #2.5 clk = ~clk;

  kp2x3_scanner #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(SYNC)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cols_n_i   (cols_n_i),
    .row_sel_o  (row_sel_o),
    .keys_o     (keys_o),
    .recovery_o (recovery_o),
    .boot_dly_o (boot_dly_o),
    .done_o     (done_o)
  );

  // Matrix model: R3 active low, R4 upper mapping, R5 lower mapping
  always_comb begin
    if (row_sel_o) cols_n_i = ~{held[0], held[1], held[2]};
    else           cols_n_i = ~{held[4], held[3], held[5]};
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected results on each done pulse
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (done_o && prev_done) check(1'b0, "R8 done width", 2, 1);
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check(keys_o == e[8:3], "R4/R5 keys", keys_o, e[8:3]);
          check(recovery_o == e[2], "R6 recovery", recovery_o, e[2]);
          check(boot_dly_o == e[1:0], "R7 boot delay", boot_dly_o, e[1:0]);
        end
      end
      prev_done = done_o;
    end
  end

  task automatic run_scan(input logic [5:0] p, input bit inject);
    logic rec;
    logic [1:0] dly;
    int n;
    rec = p[5] & p[3] & p[0];
    dly = (rec || p == 6'd0) ? 2'd0 : 2'd2;
    held = p;
    exp_q.push_back({p, rec, dly});
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(row_sel_o == 1'b0, "R1 upper first", row_sel_o, 0);
    n = 0;
    while (!row_sel_o && n < 100) begin
      @(negedge clk);
      n++;
      start_i = (inject && n == 2) ? 1'b1 : 1'b0;
    end
    start_i = 1'b0;
    check(n == W, "R2 row switch time", n, W);
    check(keys_o == prev_keys, "R8 hold mid-scan", keys_o, prev_keys);
    n = 0;
    while (!done_o && n < 100) begin
      @(negedge clk);
      n++;
      start_i = (inject && n == 3) ? 1'b1 : 1'b0;
    end
    start_i = 1'b0;
    check(n == W, "R2 done time", n, W);
    prev_keys = p;
    @(negedge clk);
    check(row_sel_o == 1'b0, "R1 idle row low", row_sel_o, 0);
    if (inject) begin
      for (int i = 0; i < 2 * W; i++) begin
        @(negedge clk);
        check(row_sel_o == 1'b0 && !done_o, "R9 no second scan", row_sel_o, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    held    = 6'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(keys_o == 0, "R10 keys", keys_o, 0);
    check(recovery_o == 0, "R10 recovery", recovery_o, 0);
    check(boot_dly_o == 0, "R10 delay", boot_dly_o, 0);
    check(done_o == 0, "R10 done", done_o, 0);
    check(row_sel_o == 0, "R10 row", row_sel_o, 0);

    run_scan(6'b000000, 1'b0);            // R7 empty -> 0
    for (int i = 0; i < 6; i++) run_scan(6'(1 << i), 1'b0); // R4, R5 single keys
    run_scan(6'b101001, 1'b0);            // R6 exact hotkey
    run_scan(6'b111111, 1'b0);            // R6 extra keys allowed
    run_scan(6'b101000, 1'b0);            // R6 missing bit 0 -> R7 code 2
    run_scan(6'b001001, 1'b0);            // R6 missing bit 5
    run_scan(6'b010110, 1'b1);            // R9 start mid-scan ignored
    run_scan(6'b101011, 1'b0);            // R6 with bit 1
    run_scan(6'b000000, 1'b0);            // R8 outputs clear on new scan

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule